// File: doc/BRIEF.md
# Memory-Increment Histogram Engine

This block is the host-side read-modify-write engine for device-requested memory breaks. A device raises a break request with a word address and a transfer direction. The engine acknowledges the request and runs a fixed four-cycle break. It reads the addressed word and then does one of three things. It can add one to the word and write it back, which is how a device counts events into histogram bins. It can hand the word out on an output bus with a strobe. It can replace the word with input data from the device. Program-visible state is never involved.

In a pulse-height analyser, the measured amplitude becomes the address and every measurement turns into one increment break. The device asserts its increment request only while the engine shows the break as active, the direction is output, and its own count condition holds. During an increment break no strobe is issued and no word goes to the device. When a bin rolls over to zero, the device receives a one-cycle wrap pulse. A small synchronous memory, written so that block RAM can be inferred, holds the bins.

Top module: `hist_incr_engine`

## Requirements
- R1: While reset is high and in the first cycle after it is released, `addr_ack`, `brk_state`, `strobe_o` and `wrap_o` are all low.
- R2: A request with `brk_req`=1 and `sel_three`=0, sampled at a clock edge while the engine is idle, starts a break. `addr_ack` is high for exactly the first cycle after that edge. `brk_state` is high for exactly four cycles, starting with that same cycle.
- R3: A request made with `sel_three`=1 is ignored. No acknowledge follows, `brk_state` stays low, and memory is unchanged.
- R4: In an output break (`dir_out`=1) whose `inc_req` is high at the edge that ends the second break cycle, the stored word is written back plus one. Any later break to the same address sees the new value.
- R5: An output break without increment raises `strobe_o` for exactly the third break cycle. During that cycle `dout` equals the stored word, and the word stays unchanged.
- R6: During an increment break `strobe_o` stays low.
- R7: Counts wrap modulo 2^DW. `wrap_o` is high for exactly the third cycle of an increment break whose result is zero, and it is low at all other times.
- R8: If `brk_req` is still high at the edge that ends the fourth break cycle, the next break starts in the following cycle. Every such back-to-back increment to the same address adds exactly one.
- R9: In an input break (`dir_out`=0), the `din` value sampled at the end of the second break cycle is written to the address. `inc_req` is ignored and no strobe is issued.
- R10: `inc_req` is sampled only at the edge that ends the second break cycle. A request raised only outside that edge leaves the word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_req | input | 1 | Break request from the device |
| sel_three | input | 1 | Selects the unsupported three-cycle break; requests made with it are ignored |
| dir_out | input | 1 | 1 = output (host to device) or increment, 0 = input |
| addr | input | AW | Word address of the break |
| din | input | DW | Input-break data word |
| inc_req | input | 1 | Increment request from the device |
| addr_ack | output | 1 | One-cycle acknowledge at the start of a break |
| brk_state | output | 1 | High while a break is in progress |
| strobe_o | output | 1 | Output-data strobe |
| dout | output | DW | Output-break data word |
| wrap_o | output | 1 | Bin rolled over to zero |

## Verification
The bench builds the engine with a 5-bit address and a 4-bit word. With those sizes the whole bin space can be cleared and read back in a few hundred cycles, and a single bin wraps after sixteen increments. That puts R7 and the modulo behaviour of R4 and R8 within reach of a short run. The same break timing applies as at the default 12-bit sizes. A held request drives twenty back-to-back increments into one bin, which crosses a wrap in the middle of the burst. A hand-timed increment request that skips the sampling edge exercises R10.

// File: rtl/hist_incr_pkg.sv
package hist_incr_pkg;

  // Phases of one break; the engine always walks ADDR -> READ -> CARRY -> DONE.
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_READ  = 3'd2,
    PH_CARRY = 3'd3,
    PH_DONE  = 3'd4
  } brk_phase_e;

endpackage

// File: rtl/hist_ram.sv
module hist_ram #(
  parameter int AW = 12,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] a,
  input  logic [DW-1:0] wd,
  output logic [DW-1:0] rq
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Single port, registered read: block RAM friendly.
  always_ff @(posedge clk) begin
    if (we) mem[a] <= wd;
    rq <= mem[a];
  end
endmodule

// File: rtl/hist_seq.sv
module hist_seq
  import hist_incr_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          brk_req,
  input  logic          sel_three,
  input  logic          dir_out,
  input  logic [AW-1:0] addr,
  output brk_phase_e    phase,
  output logic [AW-1:0] ma,
  output logic          dir_l,
  output logic          ack
);
  logic accept;
  assign accept = brk_req && !sel_three;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE;
      ma    <= '0;
      dir_l <= 1'b0;
      ack   <= 1'b0;
    end else begin
      ack <= 1'b0;
      unique case (phase)
        PH_IDLE, PH_DONE: begin
          if (accept) begin
            phase <= PH_ADDR;
            ma    <= addr;
            dir_l <= dir_out;
            ack   <= 1'b1;
          end else begin
            phase <= PH_IDLE;
          end
        end
        PH_ADDR:  phase <= PH_READ;
        PH_READ:  phase <= PH_CARRY;
        PH_CARRY: phase <= PH_DONE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hist_mb.sv
module hist_mb
  import hist_incr_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  brk_phase_e    phase,
  input  logic          dir_l,
  input  logic          inc_req,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rd_q,
  output logic [DW-1:0] mb,
  output logic          we,
  output logic          strobe,
  output logic [DW-1:0] dout,
  output logic          wrap
);
  logic          carry;
  logic [DW-1:0] sum;

  // Carry-in forced into the buffer word; the adder wraps at DW bits.
  assign carry = inc_req && dir_l;
  assign sum   = rd_q + {{(DW-1){1'b0}}, carry};
  assign we    = (phase == PH_CARRY);

  always_ff @(posedge clk) begin
    if (rst) begin
      mb     <= '0;
      strobe <= 1'b0;
      dout   <= '0;
      wrap   <= 1'b0;
    end else begin
      strobe <= 1'b0;
      wrap   <= 1'b0;
      if (phase == PH_READ) begin
        if (dir_l) begin
          mb     <= sum;
          strobe <= !carry;
          wrap   <= carry && (sum == '0);
          if (!carry) dout <= rd_q;
        end else begin
          mb <= din;
        end
      end
    end
  end
endmodule

// File: rtl/hist_incr_engine.sv
module hist_incr_engine
  import hist_incr_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          brk_req,
  input  logic          sel_three,
  input  logic          dir_out,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          inc_req,
  output logic          addr_ack,
  output logic          brk_state,
  output logic          strobe_o,
  output logic [DW-1:0] dout,
  output logic          wrap_o
);
  brk_phase_e    phase;
  logic [AW-1:0] ma;
  logic          dir_l;
  logic [DW-1:0] rd_q;
  logic [DW-1:0] mb;
  logic          we;

  hist_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst(rst), .brk_req(brk_req), .sel_three(sel_three),
    .dir_out(dir_out), .addr(addr), .phase(phase), .ma(ma),
    .dir_l(dir_l), .ack(addr_ack)
  );

  hist_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk(clk), .we(we), .a(ma), .wd(mb), .rq(rd_q)
  );

  hist_mb #(.DW(DW)) u_mb (
    .clk(clk), .rst(rst), .phase(phase), .dir_l(dir_l), .inc_req(inc_req),
    .din(din), .rd_q(rd_q), .mb(mb), .we(we), .strobe(strobe_o),
    .dout(dout), .wrap(wrap_o)
  );

  assign brk_state = (phase != PH_IDLE);
endmodule

// File: rtl/hist_incr_engine_chk.sv
module hist_incr_engine_chk (
  input logic clk,
  input logic rst,
  input logic sel_three,
  input logic addr_ack,
  input logic brk_state,
  input logic strobe_o,
  input logic wrap_o
);
  logic [2:0] since_ack;

  always_ff @(posedge clk) begin
    if (rst)            since_ack <= 3'd0;
    else if (addr_ack)  since_ack <= 3'd1;
    else if (brk_state) since_ack <= since_ack + 3'd1;
    else                since_ack <= 3'd0;
  end

  a_r2_ack_single: assert property (@(posedge clk) disable iff (rst)
    addr_ack |=> !addr_ack);
  a_r2_ack_in_break: assert property (@(posedge clk) disable iff (rst)
    addr_ack |-> brk_state);
  a_r2_break_length: assert property (@(posedge clk) disable iff (rst)
    (since_ack == 3'd3) |=> (!brk_state || addr_ack));
  a_r3_three_ignored: assert property (@(posedge clk) disable iff (rst)
    (!brk_state && sel_three) |=> !addr_ack);
  a_r5_strobe_in_break: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> (brk_state && since_ack == 3'd2));
  a_r6_no_strobe_on_inc: assert property (@(posedge clk) disable iff (rst)
    wrap_o |-> !strobe_o);
  a_r7_wrap_pulse: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> !wrap_o);
endmodule

bind hist_incr_engine hist_incr_engine_chk u_chk (
  .clk(clk), .rst(rst), .sel_three(sel_three), .addr_ack(addr_ack),
  .brk_state(brk_state), .strobe_o(strobe_o), .wrap_o(wrap_o)
);

// File: tb/hist_incr_engine_tb.sv
`timescale 1ns/1ps
module hist_incr_engine_tb;
  localparam int AW = 5;
  localparam int DW = 4;
  localparam int NB = 1 << AW;
  localparam int NV = 1 << DW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic brk_req = 1'b0, sel_three = 1'b0, dir_out = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic inc_req;
  logic addr_ack, brk_state, strobe_o, wrap_o;
  logic [DW-1:0] dout;

  logic use_gate = 1'b1, cond = 1'b0, inc_manual = 1'b0;
  assign inc_req = use_gate ? (brk_state && dir_out && cond) : inc_manual;

  hist_incr_engine #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .brk_req(brk_req), .sel_three(sel_three),
    .dir_out(dir_out), .addr(addr), .din(din), .inc_req(inc_req),
    .addr_ack(addr_ack), .brk_state(brk_state), .strobe_o(strobe_o),
    .dout(dout), .wrap_o(wrap_o)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural cycle model
  int mph = 0, mma = 0, mv = 0, e_dout = 0;
  bit mdir = 0, mcarry = 0, e_ack = 0, e_brk = 0, e_str = 0, e_wrap = 0;
  int mmem [NB];
  int hist [NB];

  always @(posedge clk) begin
    if (rst) begin
      mph = 0; e_ack = 0; e_brk = 0; e_str = 0; e_wrap = 0;
    end else begin
      e_ack = 0; e_str = 0; e_wrap = 0;
      case (mph)
        0, 4: if (brk_req && !sel_three) begin
                mph = 1; mma = int'(addr); mdir = dir_out; e_ack = 1;
              end else mph = 0;
        1: mph = 2;
        2: begin
             mcarry = inc_req && mdir;
             if (mdir) begin
               mv = (mmem[mma] + (mcarry ? 1 : 0)) % NV;
               if (!mcarry) begin e_str = 1; e_dout = mmem[mma]; end
               if (mcarry && mv == 0) e_wrap = 1;
             end else mv = int'(din);
             mph = 3;
           end
        3: begin mmem[mma] = mv; mph = 4; end
        default: mph = 0;
      endcase
      e_brk = (mph != 0);
    end
  end

  int ack_cnt = 0, str_cnt = 0, wrap_cnt = 0, cap = 0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      check(addr_ack == e_ack, "R2 addr_ack", int'(addr_ack), int'(e_ack));
      check(brk_state == e_brk, "R2 brk_state", int'(brk_state), int'(e_brk));
      check(strobe_o == e_str, "R5/R6 strobe_o", int'(strobe_o), int'(e_str));
      check(wrap_o == e_wrap, "R7 wrap_o", int'(wrap_o), int'(e_wrap));
      if (e_str) check(int'(dout) == e_dout, "R5 dout", int'(dout), e_dout);
      if (addr_ack) ack_cnt++;
      if (strobe_o) begin str_cnt++; cap = int'(dout); end
      if (wrap_o) wrap_cnt++;
    end
  end

  task automatic brk1(input int a, input bit d, input bit c, input int di);
    @(negedge clk);
    addr = AW'(a); dir_out = d; cond = c; din = DW'(di); brk_req = 1'b1;
    do @(negedge clk); while (!addr_ack);
    brk_req = 1'b0;
    while (brk_state) @(negedge clk);
  endtask

  task automatic rdback(input int a, output int v);
    int s0;
    s0 = str_cnt;
    brk1(a, 1'b1, 1'b0, 0);
    check(str_cnt == s0 + 1, "R5 strobe count", str_cnt - s0, 1);
    v = cap;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, s0, w0, a0, lf;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!addr_ack && !brk_state && !strobe_o && !wrap_o, "R1 outputs in reset",
          int'({addr_ack, brk_state, strobe_o, wrap_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!addr_ack && !brk_state && !strobe_o && !wrap_o, "R1 outputs after reset",
          int'({addr_ack, brk_state, strobe_o, wrap_o}), 0);

    // R9: clear all bins with input breaks
    for (int i = 0; i < NB; i++) begin
      brk1(i, 1'b0, 1'b0, 0);
      hist[i] = 0;
    end

    // R3: three-cycle select ignored
    a0 = ack_cnt;
    @(negedge clk);
    addr = AW'(4); dir_out = 1'b1; cond = 1'b1; sel_three = 1'b1; brk_req = 1'b1;
    repeat (8) @(negedge clk);
    check(ack_cnt == a0, "R3 no acknowledge", ack_cnt - a0, 0);
    check(!brk_state, "R3 no break", int'(brk_state), 0);
    brk_req = 1'b0; sel_three = 1'b0;
    rdback(4, v);
    check(v == 0, "R3 bin unchanged", v, 0);

    // R4/R6: scattered increments
    s0 = str_cnt;
    lf = 5;
    for (int i = 0; i < 40; i++) begin
      lf = (lf * 37 + 11) % NB;
      brk1(lf, 1'b1, 1'b1, 0);
      hist[lf] = (hist[lf] + 1) % NV;
    end
    check(str_cnt == s0, "R6 no strobe during increments", str_cnt - s0, 0);

    // R8/R7: back-to-back increments to bin 7, crossing a wrap
    w0 = wrap_cnt; a0 = ack_cnt;
    @(negedge clk);
    addr = AW'(7); dir_out = 1'b1; cond = 1'b1; brk_req = 1'b1;
    while (ack_cnt - a0 < 20) @(negedge clk);
    brk_req = 1'b0;
    while (brk_state) @(negedge clk);
    v = (hist[7] + 20) / NV;
    hist[7] = (hist[7] + 20) % NV;
    check(wrap_cnt - w0 == v, "R7 wrap pulses in burst", wrap_cnt - w0, v);
    rdback(7, v);
    check(v == hist[7], "R8 back-to-back count", v, hist[7]);

    // R9: input write ignores increment request
    use_gate = 1'b0; inc_manual = 1'b1;
    s0 = str_cnt;
    brk1(3, 1'b0, 1'b1, 9);
    inc_manual = 1'b0; use_gate = 1'b1;
    hist[3] = 9;
    check(str_cnt == s0, "R9 no strobe on input", str_cnt - s0, 0);
    rdback(3, v);
    check(v == 9, "R9 input word written", v, 9);

    // R10: increment raised only outside the sampling edge
    use_gate = 1'b0; inc_manual = 1'b1;
    @(negedge clk);
    addr = AW'(5); dir_out = 1'b1; brk_req = 1'b1;
    do @(negedge clk); while (!addr_ack);
    brk_req = 1'b0;
    @(negedge clk); inc_manual = 1'b0;      // in second break cycle
    @(negedge clk); inc_manual = 1'b1;      // third cycle onward
    while (brk_state) @(negedge clk);
    inc_manual = 1'b0; use_gate = 1'b1;
    rdback(5, v);
    check(v == hist[5], "R10 late request ignored", v, hist[5]);

    // R4: full histogram against reference
    for (int i = 0; i < NB; i++) begin
      rdback(i, v);
      check(v == hist[i], "R4 histogram bin", v, hist[i]);
    end

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule